// File: doc/BRIEF.md
# Debug monitor entry sequencer

This block decides, at the moment reset is released, whether a microcontroller enters its serial debug monitor, and then runs the opening handshake with a host computer. On the first clock edge after the active-low reset input goes high, it captures a monitor-request strap, a clock-speed strap and a high-voltage detect flag taken from the interrupt pin. These values then fix three things until the next reset: monitor mode itself, the bus clock divide ratio (with the bypass of an oscillator divide-by-two stage), and whether the watchdog may be forced off.

In monitor mode the block sits between the chip's byte-level serial receiver and transmitter. It takes a fixed number of security bytes from the host and passes each one to an external comparator as a one-cycle strobe that carries the byte index. It does not compare the bytes itself. After the last byte it waits for the next bit-period tick and then holds the transmit line low for a fixed number of bit times. This break tells the host that commands are now accepted. The line then returns high and a ready flag is set.

Top module: `monitor_entry_seq`

## Requirements
- R1: Straps are captured on the first rising clock edge with `rstN` high after reset. Later changes on `monStrap`, `clkStrap` or `hvIrq` do not change `monActive`, `busDivFour` or `oscBypass` until the next reset.
- R2: Monitor mode is entered (`monActive`=1) when `monStrap` or `hvIrq` is high at capture. When it is not entered, received bytes produce no strobe, `txLine` stays high and `cmdReady` stays 0.
- R3: With `hvIrq` high and `clkStrap` low at capture, the bus clock is input/2: `busDivFour`=0 (0 selects divide-by-two, 1 selects divide-by-four) and `oscBypass`=1.
- R4: With `hvIrq` high and `clkStrap` high at capture, the bus clock is input/4: `busDivFour`=1 and `oscBypass`=0.
- R5: With `hvIrq` low at capture, the default applies: `busDivFour`=1 and `oscBypass`=0, and `wdogEnable` stays 1 whatever `hvIrq`/`hvRst` do later.
- R6: After a high-voltage entry, `wdogEnable` is 0 in exactly the cycles in which `hvIrq` or `hvRst` is high, and 1 otherwise.
- R7: In monitor mode, each of the first SEC_BYTES (8) `rxValid` cycles gives `secByteStb`=1 for one cycle on the next clock. It carries `secByteIdx` counting 0,1,..,7 and `secByteData` equal to the received byte.
- R8: Bytes received after the last security byte (during the break or once ready) give no strobe and do not change `cmdReady`.
- R9: After the last security byte, `txLine` goes low on the next `bitTick` and stays low across exactly BREAK_BITS (10) further `bitTick` pulses.
- R10: On the tick that ends the break, `txLine` returns high and `cmdReady` becomes 1. It holds until reset.
- R11: Asserting `rstN` low clears the block at once, without waiting for a clock: `txLine`=1, `cmdReady`=0, `secByteStb`=0, `monActive`=0, `busDivFour`=1, `oscBypass`=0, and the byte count restarts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset; its release triggers strap capture |
| monStrap | input | 1 | Strap requesting monitor mode |
| clkStrap | input | 1 | Strap selecting the bus divide ratio during a high-voltage entry |
| hvIrq | input | 1 | High voltage detected on the interrupt pin |
| hvRst | input | 1 | High voltage detected on the reset pin |
| rxValid | input | 1 | One-cycle flag: a byte arrived from the host |
| rxData | input | DATA_W | Received byte |
| bitTick | input | 1 | One-cycle pulse per serial bit period |
| txLine | output | 1 | Serial transmit level, idle high |
| secByteStb | output | 1 | One-cycle strobe per security byte |
| secByteIdx | output | IDX_W | Index of the strobed security byte |
| secByteData | output | DATA_W | Value of the strobed security byte |
| monActive | output | 1 | Monitor mode latched |
| busDivFour | output | 1 | 1 = bus clock input/4, 0 = input/2 |
| oscBypass | output | 1 | Bypass the oscillator divide-by-two stage |
| wdogEnable | output | 1 | Watchdog allowed to run |
| cmdReady | output | 1 | Handshake finished, commands accepted |

## Verification
The bench runs a separate entry for each strap pattern: high voltage with the clock strap low, high voltage with it high, monitor request without high voltage, and no request at all. Together these separate the divide-by-two/bypass case from both divide-by-four cases, and separate the watchdog-gating entry from the plain one. In each case the straps and high-voltage inputs are then toggled after capture. This shows that the mode outputs are frozen, while the watchdog gate follows the live high-voltage inputs only after a high-voltage entry. The handshake is driven with distinct byte values and uneven gaps. Low bit times are counted against the tick, extra bytes are sent both during the break and after it, and reset is asserted mid-cycle to check that it clears at once.

// File: rtl/mes_pkg.sv
package mes_pkg;

  typedef enum logic [2:0] {
    ST_CAPTURE = 3'd0,
    ST_OFF     = 3'd1,
    ST_COLLECT = 3'd2,
    ST_BRK_ARM = 3'd3,
    ST_BRK     = 3'd4,
    ST_READY   = 3'd5
  } mesState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic byteTake;
    logic brkLow;
    logic bitStep;
    logic brkEnd;
  } mesCtrl_t;

  // conditions reported back by the datapath
  typedef struct packed {
    logic entryReq;
    logic byteLast;
    logic bitLast;
  } mesStat_t;

endpackage

// File: rtl/mes_ctrl.sv
module mes_ctrl
  import mes_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     rxValid,
  input  logic     bitTick,
  input  mesStat_t stat,
  output mesCtrl_t ctrl
);

  mesState_e stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_CAPTURE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    ctrl   = '0;
    unique case (stateQ)
      ST_CAPTURE: begin
        ctrl.capture = 1'b1;
        stateD = stat.entryReq ? ST_COLLECT : ST_OFF;
      end
      ST_OFF: stateD = ST_OFF;
      ST_COLLECT: begin
        if (rxValid) begin
          ctrl.byteTake = 1'b1;
          if (stat.byteLast) stateD = ST_BRK_ARM;
        end
      end
      ST_BRK_ARM: begin
        if (bitTick) begin
          ctrl.brkLow = 1'b1;
          stateD = ST_BRK;
        end
      end
      ST_BRK: begin
        if (bitTick) begin
          if (stat.bitLast) begin
            ctrl.brkEnd = 1'b1;
            stateD = ST_READY;
          end else begin
            ctrl.bitStep = 1'b1;
          end
        end
      end
      ST_READY: stateD = ST_READY;
      default:  stateD = ST_CAPTURE;
    endcase
  end

endmodule

// File: rtl/mes_datapath.sv
module mes_datapath
  import mes_pkg::*;
#(
  parameter int SEC_BYTES  = 8,
  parameter int BREAK_BITS = 10,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1,
  localparam int BIT_W     = $clog2(BREAK_BITS + 1)
)(
  input  logic              clk,
  input  logic              rstN,
  input  mesCtrl_t          ctrl,
  input  logic              monStrap,
  input  logic              clkStrap,
  input  logic              hvIrq,
  input  logic              hvRst,
  input  logic [DATA_W-1:0] rxData,
  output mesStat_t          stat,
  output logic              txLine,
  output logic              secByteStb,
  output logic [IDX_W-1:0]  secByteIdx,
  output logic [DATA_W-1:0] secByteData,
  output logic              monActive,
  output logic              busDivFour,
  output logic              oscBypass,
  output logic              wdogEnable,
  output logic              cmdReady
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEC_BYTES - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BREAK_BITS - 1);

  logic             hvEntryQ;
  logic [IDX_W-1:0] byteCntQ;
  logic [BIT_W-1:0] bitCntQ;

  // strap capture, frozen after the first cycle out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      monActive  <= 1'b0;
      hvEntryQ   <= 1'b0;
      busDivFour <= 1'b1;
      oscBypass  <= 1'b0;
    end else if (ctrl.capture) begin
      monActive  <= monStrap | hvIrq;
      hvEntryQ   <= hvIrq;
      busDivFour <= ~(hvIrq & ~clkStrap);
      oscBypass  <= hvIrq & ~clkStrap;
    end
  end

  // security byte counter and strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCntQ    <= '0;
      secByteStb  <= 1'b0;
      secByteIdx  <= '0;
      secByteData <= '0;
    end else begin
      secByteStb <= ctrl.byteTake;
      if (ctrl.byteTake) begin
        secByteIdx  <= byteCntQ;
        secByteData <= rxData;
        byteCntQ    <= byteCntQ + 1'b1;
      end
    end
  end

  // break bit counter, line level and ready flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCntQ  <= '0;
      txLine   <= 1'b1;
      cmdReady <= 1'b0;
    end else begin
      if (ctrl.brkLow) begin
        txLine  <= 1'b0;
        bitCntQ <= '0;
      end
      if (ctrl.bitStep) bitCntQ <= bitCntQ + 1'b1;
      if (ctrl.brkEnd) begin
        txLine   <= 1'b1;
        cmdReady <= 1'b1;
      end
    end
  end

  assign wdogEnable    = ~(hvEntryQ & (hvIrq | hvRst));
  assign stat.entryReq = monStrap | hvIrq;
  assign stat.byteLast = (byteCntQ == LAST_IDX);
  assign stat.bitLast  = (bitCntQ == LAST_BIT);

endmodule

// File: rtl/monitor_entry_seq.sv
module monitor_entry_seq
  import mes_pkg::*;
#(
  parameter int SEC_BYTES  = 8,
  parameter int BREAK_BITS = 10,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = (SEC_BYTES > 1) ? $clog2(SEC_BYTES) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              monStrap,
  input  logic              clkStrap,
  input  logic              hvIrq,
  input  logic              hvRst,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              bitTick,
  output logic              txLine,
  output logic              secByteStb,
  output logic [IDX_W-1:0]  secByteIdx,
  output logic [DATA_W-1:0] secByteData,
  output logic              monActive,
  output logic              busDivFour,
  output logic              oscBypass,
  output logic              wdogEnable,
  output logic              cmdReady
);

  mesCtrl_t ctrl;
  mesStat_t stat;

  mes_ctrl ctrlI (
    .clk     (clk),
    .rstN    (rstN),
    .rxValid (rxValid),
    .bitTick (bitTick),
    .stat    (stat),
    .ctrl    (ctrl)
  );

  mes_datapath #(
    .SEC_BYTES  (SEC_BYTES),
    .BREAK_BITS (BREAK_BITS),
    .DATA_W     (DATA_W)
  ) dpI (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .monStrap    (monStrap),
    .clkStrap    (clkStrap),
    .hvIrq       (hvIrq),
    .hvRst       (hvRst),
    .rxData      (rxData),
    .stat        (stat),
    .txLine      (txLine),
    .secByteStb  (secByteStb),
    .secByteIdx  (secByteIdx),
    .secByteData (secByteData),
    .monActive   (monActive),
    .busDivFour  (busDivFour),
    .oscBypass   (oscBypass),
    .wdogEnable  (wdogEnable),
    .cmdReady    (cmdReady)
  );

endmodule

// File: rtl/monitor_entry_seq_chk.sv
module monitor_entry_seq_chk #(
  parameter int BREAK_BITS = 10,
  localparam int CNT_W     = $clog2(BREAK_BITS + 1) + 1
)(
  input logic clk,
  input logic rstN,
  input logic hvIrq,
  input logic hvRst,
  input logic bitTick,
  input logic txLine,
  input logic secByteStb,
  input logic monActive,
  input logic busDivFour,
  input logic oscBypass,
  input logic wdogEnable,
  input logic cmdReady
);

  logic [1:0]       cycSinceRst;
  logic [CNT_W-1:0] lowTicks;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cycSinceRst <= '0;
    else if (cycSinceRst != 2'd3) cycSinceRst <= cycSinceRst + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        lowTicks <= '0;
    else if (txLine)  lowTicks <= '0;
    else if (bitTick) lowTicks <= lowTicks + 1'b1;
  end

  // R1: mode outputs frozen once capture is done
  assert_straps_frozen_R1: assert property (@(posedge clk) disable iff (!rstN)
    (cycSinceRst >= 2'd2) |-> ($stable(monActive) && $stable(busDivFour) && $stable(oscBypass)));

  // R2: no strobe, break or ready without monitor mode
  assert_idle_without_monitor_R2: assert property (@(posedge clk) disable iff (!rstN)
    !monActive |-> (!secByteStb && txLine && !cmdReady));

  // R3: bypass only accompanies divide-by-two
  assert_bypass_means_div2_R3: assert property (@(posedge clk) disable iff (!rstN)
    oscBypass |-> !busDivFour);

  // R6: watchdog never gated off without a live high-voltage input
  assert_wdog_needs_hv_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!hvIrq && !hvRst) |-> wdogEnable);

  // R8: no strobe once ready
  assert_no_strobe_when_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !secByteStb);

  // R9: break never longer than its bit count
  assert_break_length_R9: assert property (@(posedge clk) disable iff (!rstN)
    lowTicks <= CNT_W'(BREAK_BITS));

  // R10: ready rises exactly when the full break has elapsed, and then holds high with the line idle
  assert_ready_after_full_break_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdReady) |-> (lowTicks == CNT_W'(BREAK_BITS)));
  assert_ready_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |=> (cmdReady && txLine));

  // R11: outputs held in their cleared state while reset is low
  always @(negedge clk) begin
    if (!rstN) begin
      assert_reset_clear_R11: assert (txLine && !cmdReady && !secByteStb && !monActive);
    end
  end

endmodule

bind monitor_entry_seq monitor_entry_seq_chk #(.BREAK_BITS(BREAK_BITS)) chkI (
  .clk        (clk),
  .rstN       (rstN),
  .hvIrq      (hvIrq),
  .hvRst      (hvRst),
  .bitTick    (bitTick),
  .txLine     (txLine),
  .secByteStb (secByteStb),
  .monActive  (monActive),
  .busDivFour (busDivFour),
  .oscBypass  (oscBypass),
  .wdogEnable (wdogEnable),
  .cmdReady   (cmdReady)
);

// File: tb/monitor_entry_seq_tb_top.sv
`timescale 1ns/1ps
module monitor_entry_seq_tb_top;

  localparam int SEC_BYTES  = 8;
  localparam int BREAK_BITS = 10;
  localparam int DATA_W     = 8;
  localparam int IDX_W      = 3;
  localparam int TICK_DIV   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic monStrap = 1'b0, clkStrap = 1'b0, hvIrq = 1'b0, hvRst = 1'b0;
  logic rxValid = 1'b0;
  logic [DATA_W-1:0] rxData = '0;
  logic bitTick = 1'b0;
  logic txLine, secByteStb, monActive, busDivFour, oscBypass, wdogEnable, cmdReady;
  logic [IDX_W-1:0]  secByteIdx;
  logic [DATA_W-1:0] secByteData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  monitor_entry_seq #(.SEC_BYTES(SEC_BYTES), .BREAK_BITS(BREAK_BITS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN), .monStrap(monStrap), .clkStrap(clkStrap),
    .hvIrq(hvIrq), .hvRst(hvRst), .rxValid(rxValid), .rxData(rxData),
    .bitTick(bitTick), .txLine(txLine), .secByteStb(secByteStb),
    .secByteIdx(secByteIdx), .secByteData(secByteData), .monActive(monActive),
    .busDivFour(busDivFour), .oscBypass(oscBypass), .wdogEnable(wdogEnable),
    .cmdReady(cmdReady)
  );

  // bit-period tick: one cycle high every TICK_DIV cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      bitTick <= (cnt == TICK_DIV - 1);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // wait to just after the next falling edge
  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #0.5;
    end
  endtask

  task automatic enterWith(input logic m, input logic c, input logic h);
    step();
    rstN = 1'b0;
    monStrap = m; clkStrap = c; hvIrq = h; hvRst = 1'b0;
    rxValid = 1'b0;
    step(2);
    check(txLine == 1'b1 && cmdReady == 1'b0 && secByteStb == 1'b0, "R11 reset outputs", {txLine, cmdReady, secByteStb}, 3'b100);
    check(monActive == 1'b0 && busDivFour == 1'b1 && oscBypass == 1'b0, "R11 reset mode", {monActive, busDivFour, oscBypass}, 3'b010);
    rstN = 1'b1;
    step(2);
  endtask

  task automatic sendByte(input logic [DATA_W-1:0] b);
    rxData = b;
    rxValid = 1'b1;
    step();
    rxValid = 1'b0;
  endtask

  task automatic testHvDiv2;
    enterWith(1'b0, 1'b0, 1'b1);
    check(monActive == 1'b1, "R2 hv entry", monActive, 1);
    check(busDivFour == 1'b0 && oscBypass == 1'b1, "R3 div2 bypass", {busDivFour, oscBypass}, 2'b01);
    check(wdogEnable == 1'b0, "R6 wdog off hvIrq", wdogEnable, 0);
    clkStrap = 1'b1; monStrap = 1'b1;
    step(3);
    check(busDivFour == 1'b0 && oscBypass == 1'b1 && monActive == 1'b1, "R1 strap change ignored", {monActive, busDivFour, oscBypass}, 3'b101);
    hvIrq = 1'b0;
    step();
    check(wdogEnable == 1'b1, "R6 wdog back on", wdogEnable, 1);
    hvRst = 1'b1;
    step();
    check(wdogEnable == 1'b0, "R6 wdog off hvRst", wdogEnable, 0);
    hvRst = 1'b0;
    step();
    check(busDivFour == 1'b0 && monActive == 1'b1, "R1 hv drop ignored", {monActive, busDivFour}, 2'b10);
  endtask

  task automatic testHvDiv4;
    enterWith(1'b0, 1'b1, 1'b1);
    check(busDivFour == 1'b1 && oscBypass == 1'b0, "R4 div4", {busDivFour, oscBypass}, 2'b10);
    clkStrap = 1'b0;
    step(3);
    check(busDivFour == 1'b1 && oscBypass == 1'b0, "R1 clkStrap change ignored", {busDivFour, oscBypass}, 2'b10);
  endtask

  task automatic testPlainMon;
    enterWith(1'b1, 1'b0, 1'b0);
    check(monActive == 1'b1 && busDivFour == 1'b1 && oscBypass == 1'b0, "R5 default div4", {monActive, busDivFour, oscBypass}, 3'b110);
    hvIrq = 1'b1; hvRst = 1'b1;
    step();
    check(wdogEnable == 1'b1, "R5 wdog not forced", wdogEnable, 1);
    check(busDivFour == 1'b1 && oscBypass == 1'b0, "R1 late hv ignored", {busDivFour, oscBypass}, 2'b10);
    hvIrq = 1'b0; hvRst = 1'b0;
  endtask

  task automatic testNoMon;
    int stbSeen = 0;
    enterWith(1'b0, 1'b0, 1'b0);
    check(monActive == 1'b0, "R2 no entry", monActive, 0);
    for (int i = 0; i < SEC_BYTES + 2; i++) begin
      sendByte(8'h30 + 8'(i));
      if (secByteStb) stbSeen++;
      step();
    end
    step(60);
    check(stbSeen == 0, "R2 no strobe", stbSeen, 0);
    check(txLine == 1'b1 && cmdReady == 1'b0, "R2 no break", {txLine, cmdReady}, 2'b10);
  endtask

  task automatic testHandshake;
    int lowTicks = 0;
    int stbLate = 0;
    int guard = 0;
    logic [DATA_W-1:0] b;
    enterWith(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < SEC_BYTES; i++) begin
      b = 8'hA5 ^ 8'(i * 37);
      sendByte(b);
      check(secByteStb == 1'b1 && secByteIdx == IDX_W'(i) && secByteData == b, "R7 strobe idx/data",
            {secByteStb, 5'(secByteIdx), secByteData}, {1'b1, 5'(i), b});
      if (i < SEC_BYTES - 1) begin
        check(txLine == 1'b1, "R9 line idle while collecting", txLine, 1);
        step(i % 3);
        check(secByteStb == 1'b0 || (i % 3) == 0, "R7 strobe one cycle", secByteStb, 0);
      end
    end
    // watch the break, counting ticks that land while the line is low
    while (!cmdReady && guard < 400) begin
      if (bitTick && !txLine) lowTicks++;
      if (!txLine && guard == 20) begin
        sendByte(8'h5A);
        if (secByteStb) stbLate++;
      end else begin
        step();
      end
      guard++;
    end
    check(lowTicks == BREAK_BITS, "R9 break bit times", lowTicks, BREAK_BITS);
    check(cmdReady == 1'b1 && txLine == 1'b1, "R10 ready line high", {cmdReady, txLine}, 2'b11);
    sendByte(8'h77);
    if (secByteStb) stbLate++;
    step(5);
    check(stbLate == 0, "R8 late bytes ignored", stbLate, 0);
    check(cmdReady == 1'b1 && txLine == 1'b1, "R10 ready holds", {cmdReady, txLine}, 2'b11);
    // asynchronous reset mid-cycle
    #1;
    rstN = 1'b0;
    #0.5;
    check(cmdReady == 1'b0 && txLine == 1'b1 && monActive == 1'b0, "R11 async clear", {cmdReady, txLine, monActive}, 3'b010);
    step();
    rstN = 1'b1;
    step(2);
    b = 8'hC3;
    sendByte(b);
    check(secByteStb == 1'b1 && secByteIdx == '0, "R11 counter restarts", 5'(secByteIdx), 0);
  endtask

  initial begin
    testHvDiv2();
    testHvDiv4();
    testPlainMon();
    testNoMon();
    testHandshake();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule